// File: doc/BRIEF.md
# Segmented Lookup-Table Multiplier

This block multiplies two unsigned binary operands without a full-width multiplier array. Both operands are zero-extended to a whole number of 3-bit groups. Each 3-bit group of operand A is paired with every 3-bit slice of operand B. A small 64-entry product table returns the 6-bit product for each pair.

The slice products for one group of A are shifted to their slice weights and summed into a row. That row is the partial product of that group with the whole of B. The rows are then shifted by their group weights and added to form the exact double-width product.

The datapath is a two-stage pipeline. The rows are registered in the first stage, and the accumulated product is registered in the second. A new operand pair can be issued on every cycle with a one-cycle start pulse. The matching result appears with a one-cycle done strobe.

Top module: `slm_mult`

## Requirements
- R1: The product table is addressed by {x, y}, where x is the 3-bit A group and y is the 3-bit B slice. It returns x*y as 6 bits; for example 7×7 gives 110001, 5×7 gives 100011, 6×6 gives 100100 and 3×5 gives 001111. At the ports, a=7,b=7 gives 49 and a=3,b=5 gives 15.
- R2: Operand A is cut into non-overlapping 3-bit groups starting at bit 0. When WIDTH is not a multiple of 3, both operands are zero-extended to the next multiple of 3.
- R3: The product is 2*WIDTH bits wide and is never truncated. The padded sum never carries into bits above 2*WIDTH-1.
- R4: The partial product of A group g is shifted left by 3*g bits before accumulation. An operand A with a single nonzero group g gives a product of (group value × B) << 3g.
- R5: For any pair of operands, the product equals the exact unsigned product a*b.
- R6: When start is high in the cycle before clock edge t, done is high for exactly the cycle after edge t+1, that is two cycles later. Done is low in all other cycles.
- R7: A zero on either operand gives a product of zero.
- R8: Both operands all-ones give (2^WIDTH-1)^2.
- R9: Starts on consecutive cycles each produce their own result, one per cycle, in issue order.
- R10: Reset drives product and done to 0. Between results, product keeps the last value delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operand pair valid this cycle |
| op_a | input | WIDTH | Unsigned multiplicand, split into groups |
| op_b | input | WIDTH | Unsigned multiplier, split into slices |
| product | output | 2*WIDTH | Exact product of the pair issued two cycles earlier |
| done | output | 1 | Product is new this cycle |

## Verification
Small single-group operands such as 7×7 and 3×5 reach individual table entries at the ports. Operands with one nonzero group placed at different positions separate a wrong group shift from a wrong table entry. Zero and all-ones operands expose a lost carry or a truncated top bit, and pseudo-random pairs cover the mixed case. Back-to-back starts followed by idle gaps distinguish the per-cycle issue path from the hold of the last result.

// File: rtl/slm_pkg.sv
package slm_pkg;
    localparam int GRP_W  = 3;
    localparam int LUT_AW = 2 * GRP_W;
    localparam int LUT_DW = 2 * GRP_W;
    localparam int LUT_N  = 1 << LUT_AW;
endpackage

// File: rtl/slm_lut3.sv
module slm_lut3
    import slm_pkg::*;
(
    input  logic [LUT_AW-1:0] addr,
    output logic [LUT_DW-1:0] prod
);
    logic [LUT_DW-1:0] tbl [LUT_N];

    always_comb begin
        for (int i = 0; i < LUT_N; i++) begin
            tbl[i] = LUT_DW'((i >> GRP_W) * (i % (1 << GRP_W)));
        end
    end

    assign prod = tbl[addr];

    // R1: no 3x3 entry exceeds 7*7
    always_comb begin
        p_lut_range_r1: assert (prod <= LUT_DW'(49));
    end
endmodule

// File: rtl/slm_row.sv
module slm_row
    import slm_pkg::*;
#(
    parameter int NG = 6,
    localparam int PW = NG * GRP_W,
    localparam int RW = PW + GRP_W
) (
    input  logic [GRP_W-1:0] a_grp,
    input  logic [PW-1:0]    b_op,
    output logic [RW-1:0]    row
);
    logic [NG-1:0][LUT_DW-1:0] pp;

    for (genvar j = 0; j < NG; j++) begin : g_slice
        slm_lut3 u_lut (
            .addr ({a_grp, b_op[j*GRP_W +: GRP_W]}),
            .prod (pp[j])
        );
    end

    always_comb begin
        row = '0;
        for (int j = 0; j < NG; j++) begin
            row = row + (RW'(pp[j]) << (GRP_W * j));
        end
    end
endmodule

// File: rtl/slm_acc.sv
module slm_acc
    import slm_pkg::*;
#(
    parameter int NG = 6,
    localparam int PW = NG * GRP_W,
    localparam int RW = PW + GRP_W,
    localparam int FW = 2 * PW
) (
    input  logic [NG-1:0][RW-1:0] rows,
    output logic [FW-1:0]         sum
);
    always_comb begin
        sum = '0;
        for (int g = 0; g < NG; g++) begin
            sum = sum + (FW'(rows[g]) << (GRP_W * g));
        end
    end
endmodule

// File: rtl/slm_mult.sv
module slm_mult
    import slm_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] product,
    output logic               done
);
    localparam int NG = (WIDTH + GRP_W - 1) / GRP_W;
    localparam int PW = NG * GRP_W;
    localparam int RW = PW + GRP_W;
    localparam int FW = 2 * PW;
    localparam int OW = 2 * WIDTH;

    typedef struct packed {
        logic                  vld;
        logic [NG-1:0][RW-1:0] rows;
        logic                  done;
        logic [OW-1:0]         prod;
    } st_t;

    st_t st_d, st_q;

    logic [PW-1:0]         a_pad, b_pad;
    logic [NG-1:0][RW-1:0] row_w;
    logic [FW-1:0]         sum_w;

    assign a_pad = PW'(op_a);
    assign b_pad = PW'(op_b);

    for (genvar g = 0; g < NG; g++) begin : g_row
        slm_row #(.NG(NG)) u_row (
            .a_grp (a_pad[g*GRP_W +: GRP_W]),
            .b_op  (b_pad),
            .row   (row_w[g])
        );
    end

    slm_acc #(.NG(NG)) u_acc (
        .rows (st_q.rows),
        .sum  (sum_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = start;
        if (start) begin
            st_d.rows = row_w;
        end
        st_d.done = st_q.vld;
        if (st_q.vld) begin
            st_d.prod = sum_w[OW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign product = st_q.prod;
    assign done    = st_q.done;

    // cycles since reset, saturating, so $past never reaches before reset
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    p_done_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (done == $past(start, 2)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && !$past(st_q.vld)) |-> $stable(product));

    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.rows == '0) |=> (product == '0));

    if (FW > OW) begin : g_ovf
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.vld |-> (sum_w[FW-1:OW] == '0));
    end
endmodule

// File: tb/slm_mult_tb.sv
module slm_mult_tb;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   op_a = '0;
    logic [W-1:0]   op_b = '0;
    logic [2*W-1:0] product;
    logic           done;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R10";

    always #2 clk = ~clk;

    slm_mult #(.WIDTH(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product),
        .done    (done)
    );

    // behavioural reference: two-deep delay of (valid, a*b, tag)
    logic           m1_v = 1'b0, m2_v = 1'b0;
    logic [2*W-1:0] m1_p = '0, m2_p = '0;
    string          m1_t = "", m2_t = "";

    always @(posedge clk) begin
        if (!rst_n) begin
            m1_v <= 1'b0; m2_v <= 1'b0; m2_p <= '0;
        end else begin
            m1_v <= start;
            m1_p <= (2*W)'(op_a) * (2*W)'(op_b);
            m1_t <= cur_tag;
            m2_v <= m1_v;
            if (m1_v) begin
                m2_p <= m1_p;
                m2_t <= m1_t;
            end
        end
    end

    always @(negedge clk) begin
        checks++;
        if (done !== m2_v) begin
            errors++;
            $display("FAIL R6 done got %0b expected %0b", done, m2_v);
        end
        checks++;
        if (product !== m2_p) begin
            errors++;
            $display("FAIL %s product got %0h expected %0h (R5 R10)",
                     m2_v ? m2_t : "R10", product, m2_p);
        end
    end

    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        @(negedge clk);
        start = 1'b1; op_a = a; op_b = b; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0; op_a = $urandom; op_b = $urandom;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        issue(16'd7, 16'd7, "R1");
        idle(3);
        issue(16'd3, 16'd5, "R1");
        issue(16'd5, 16'd7, "R1");
        issue(16'd6, 16'd6, "R1");
        idle(3);
        for (int g = 0; g < 6; g++) begin
            issue(W'(5 << (3*g)), 16'hBEEF, "R4");
            idle(1);
        end
        issue(16'h8000, 16'h8001, "R2");
        issue(16'h0000, 16'hFFFF, "R7");
        issue(16'hFFFF, 16'h0000, "R7");
        idle(2);
        issue(16'hFFFF, 16'hFFFF, "R8");
        issue(16'hFFFF, 16'hFFFE, "R3");
        idle(4);
        for (int i = 0; i < 40; i++) begin
            issue(W'($urandom), W'($urandom), "R9");
        end
        idle(3);
        for (int i = 0; i < 200; i++) begin
            issue(W'($urandom), W'($urandom), "R5");
            idle(i % 3);
        end
        idle(5);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule